// File: doc/BRIEF.md
# Configuration register software-access sequencer

This block gives a host access to the 16-bit configuration register of a pseudo-static RAM using only ordinary bus cycles, so the sleep pin is not needed. The host presents a command with a value for one cycle. The command is either a load or a read-back. The block then runs a fixed handshake of four asynchronous operations against the topmost word address. It drives them through a cycle-level request/acknowledge interface to the basic bus engine, which owns pin timing. A read-back returns the data that the fourth operation captures.

Before it starts any bus traffic, the block checks each load. Values that set reserved bits are refused. Values that would select deep power-down are also refused, because that mode must not be set up through this path. For each accepted load the block keeps a shadow copy of the register. After the first accepted load, it also keeps a sticky flag. The flag reports that the sleep pin no longer starts partial-array refresh.

Top module: `cfgreg_swseq`

## Requirements
- R1: After reset, `cfg_shadow` is 0x0070, `pin_sleep_blocked`, `busy`, `done`, `reject` and `bus_req` are all 0.
- R2: Each operation of a sequence uses `bus_addr` = all ones (0xFFFFF at the default width). `bus_req`, `bus_we` and `bus_wdata` hold steady until the cycle in which `bus_ack` is high, and the next operation follows with no idle cycle.
- R3: A load (`cmd_is_read`=0) issues read, read, write, write. The fourth operation writes the command value.
- R4: A read-back (`cmd_is_read`=1) issues read, read, write, read. `rd_value` takes `bus_rdata` from the fourth operation. In both sequences the third operation writes 0x0000.
- R5: A load whose bits 15:8 or bit 3 are nonzero is refused. `reject` pulses for one cycle, in the cycle after the command, and no bus operation is issued.
- R6: A load with bit 4 (sleep-mode select, 1 = partial refresh, 0 = deep power-down) equal to 0 is refused in the same way as R5.
- R7: An accepted load copies the whole value into `cfg_shadow` when its fourth operation completes. The page bit 7, the refresh temperature bits 6:5 and the coverage bits 2:0 pass through unchanged, including coverage codes other than 000 and 100.
- R8: `pin_sleep_blocked` rises when an accepted load completes. Only reset clears it, and read-backs never set it.
- R9: `busy` is high from the cycle after a command is accepted until the fourth acknowledge has been taken. A command presented while busy is ignored.
- R10: `done` pulses for one cycle as `busy` falls. `rd_value` changes only together with `done` after a read-back. Loads and refused commands leave `rd_value` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_is_read | input | 1 | 1 = read-back, 0 = load |
| cmd_value | input | 16 | Value to load |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| reject | output | 1 | Load refused pulse |
| rd_value | output | 16 | Last register value read back |
| cfg_shadow | output | 16 | Copy of the last accepted load |
| pin_sleep_blocked | output | 1 | Sleep pin no longer starts partial refresh |
| bus_req | output | 1 | Operation request to bus engine |
| bus_we | output | 1 | 1 = write operation |
| bus_addr | output | ADDR_W | Operation address |
| bus_wdata | output | 16 | Write data |
| bus_ack | input | 1 | Operation completed |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |

## Verification
The embedded properties assume that the bus engine raises `bus_ack` only in cycles where `bus_req` is high, and that it completes exactly one operation per acknowledged cycle. The bench's engine model acknowledges only while a request is pending, with a configurable latency of zero or more cycles, and it returns read data in the same cycle as the acknowledge. The host stimulus changes the command inputs only between clock edges and pulses `cmd_valid` for a single cycle. It deliberately pulses `cmd_valid` once while a sequence is running.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  localparam int CFG_W = 16;
  localparam int SEQ_LEN = 4;
  localparam logic [CFG_W-1:0] CFG_RESET = 16'h0070;
  localparam logic [CFG_W-1:0] CFG_RSVD_MASK = 16'hFF08;
  localparam int SLEEP_BIT = 4;

  // A load is acceptable when no reserved bit is set and the sleep mode
  // selects partial refresh.
  function automatic logic cfg_value_ok(input logic [CFG_W-1:0] v);
    return ((v & CFG_RSVD_MASK) == '0) && v[SLEEP_BIT];
  endfunction

  // Operation kind for position idx of the handshake.
  function automatic logic op_is_write(input logic is_rd, input int unsigned idx);
    return (idx == SEQ_LEN - 2) || ((idx == SEQ_LEN - 1) && !is_rd);
  endfunction
endpackage

// File: rtl/cfgseq_check.sv
module cfgseq_check
  import cfgseq_pkg::*;
(
  input  logic             cmd_is_read,
  input  logic [CFG_W-1:0] cmd_value,
  output logic             cmd_ok
);
  always_comb begin
    cmd_ok = cmd_is_read || cfg_value_ok(cmd_value);
  end
endmodule

// File: rtl/cfgseq_fsm.sv
module cfgseq_fsm
  import cfgseq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              start_is_rd,
  input  logic [CFG_W-1:0]  start_value,
  output logic              active,
  output logic              cur_is_rd,
  output logic [CFG_W-1:0]  cur_value,
  output logic              last_ack,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [CFG_W-1:0]  bus_wdata,
  input  logic              bus_ack
);
  localparam int IDX_W = $clog2(SEQ_LEN);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

  logic [IDX_W-1:0] op_idx;

  always_comb begin
    bus_req   = active;
    bus_addr  = '1;
    bus_we    = active && op_is_write(cur_is_rd, int'(op_idx));
    bus_wdata = (bus_we && op_idx == LAST_IDX) ? cur_value : '0;
    last_ack  = active && bus_ack && (op_idx == LAST_IDX);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      op_idx    <= '0;
      cur_is_rd <= 1'b0;
      cur_value <= '0;
    end else if (start) begin
      active    <= 1'b1;
      op_idx    <= '0;
      cur_is_rd <= start_is_rd;
      cur_value <= start_value;
    end else if (active && bus_ack) begin
      if (op_idx == LAST_IDX) active <= 1'b0;
      else op_idx <= op_idx + 1'b1;
    end
  end

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) && $stable(bus_wdata)));
  // R2
  back_to_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && !last_ack) |=> bus_req);
  // R3
  first_op_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (bus_req && !bus_we));
endmodule

// File: rtl/cfgseq_result.sv
module cfgseq_result
  import cfgseq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             last_ack,
  input  logic             cur_is_rd,
  input  logic [CFG_W-1:0] cur_value,
  input  logic [CFG_W-1:0] bus_rdata,
  input  logic             refuse,
  output logic             done,
  output logic             reject,
  output logic [CFG_W-1:0] rd_value,
  output logic [CFG_W-1:0] cfg_shadow,
  output logic             pin_sleep_blocked
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done              <= 1'b0;
      reject            <= 1'b0;
      rd_value          <= '0;
      cfg_shadow        <= CFG_RESET;
      pin_sleep_blocked <= 1'b0;
    end else begin
      done   <= last_ack;
      reject <= refuse;
      if (last_ack) begin
        if (cur_is_rd) begin
          rd_value <= bus_rdata;
        end else begin
          cfg_shadow        <= cur_value;
          pin_sleep_blocked <= 1'b1;
        end
      end
    end
  end

  // R8
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(pin_sleep_blocked));
  // R6
  shadow_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_shadow) |-> (cfg_value_ok(cfg_shadow) && pin_sleep_blocked));
  // R10
  rd_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_value) |-> done);
endmodule

// File: rtl/cfgreg_swseq.sv
module cfgreg_swseq
  import cfgseq_pkg::*;
#(
  parameter int ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_is_read,
  input  logic [15:0]       cmd_value,
  output logic              busy,
  output logic              done,
  output logic              reject,
  output logic [15:0]       rd_value,
  output logic [15:0]       cfg_shadow,
  output logic              pin_sleep_blocked,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [15:0]       bus_wdata,
  input  logic              bus_ack,
  input  logic [15:0]       bus_rdata
);
  logic             cmd_ok;
  logic             start;
  logic             refuse;
  logic             active;
  logic             cur_is_rd;
  logic [CFG_W-1:0] cur_value;
  logic             last_ack;

  cfgseq_check u_check (
    .cmd_is_read (cmd_is_read),
    .cmd_value   (cmd_value),
    .cmd_ok      (cmd_ok)
  );

  always_comb begin
    start  = cmd_valid && !active && cmd_ok;
    refuse = cmd_valid && !active && !cmd_ok;
    busy   = active;
  end

  cfgseq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_is_rd (cmd_is_read),
    .start_value (cmd_value),
    .active      (active),
    .cur_is_rd   (cur_is_rd),
    .cur_value   (cur_value),
    .last_ack    (last_ack),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_ack     (bus_ack)
  );

  cfgseq_result u_result (
    .clk               (clk),
    .rst_n             (rst_n),
    .last_ack          (last_ack),
    .cur_is_rd         (cur_is_rd),
    .cur_value         (cur_value),
    .bus_rdata         (bus_rdata),
    .refuse            (refuse),
    .done              (done),
    .reject            (reject),
    .rd_value          (rd_value),
    .cfg_shadow        (cfg_shadow),
    .pin_sleep_blocked (pin_sleep_blocked)
  );

  // R5
  reject_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> (!bus_req && !done));
  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd_valid) |=> !reject);
endmodule

// File: tb/cfgreg_swseq_tb_top.sv
module cfgreg_swseq_tb_top;
  localparam int ADDR_W = 20;
  localparam logic [15:0] MEM_WORD = 16'hBEEF;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic cmd_is_read = 1'b0;
  logic [15:0] cmd_value = '0;
  logic busy, done, reject, pin_sleep_blocked;
  logic [15:0] rd_value, cfg_shadow;
  logic bus_req, bus_we;
  logic [ADDR_W-1:0] bus_addr;
  logic [15:0] bus_wdata;
  logic bus_ack = 1'b0;
  logic [15:0] bus_rdata = '0;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int wait_cnt = 0;
  int op_cnt = 0;
  int cyc = 0;
  logic [15:0] dev_cr = 16'h0070;
  logic log_we [8];
  logic [ADDR_W-1:0] log_addr [8];
  logic [15:0] log_wd [8];

  always #10 clk = ~clk;

  cfgreg_swseq #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_read(cmd_is_read),
    .cmd_value(cmd_value), .busy(busy), .done(done), .reject(reject),
    .rd_value(rd_value), .cfg_shadow(cfg_shadow), .pin_sleep_blocked(pin_sleep_blocked),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_rdata(bus_rdata)
  );

  // Bus engine model: acknowledges a pending request after lat cycles.
  always @(negedge clk) begin
    bus_ack = 1'b0;
    if (rst_n && bus_req) begin
      if (wait_cnt >= lat) begin
        wait_cnt = 0;
        bus_ack = 1'b1;
        if (op_cnt < 8) begin
          log_we[op_cnt] = bus_we;
          log_addr[op_cnt] = bus_addr;
          log_wd[op_cnt] = bus_wdata;
        end
        if (bus_we) begin
          if (op_cnt % 4 == 3) dev_cr = bus_wdata;
          bus_rdata = '0;
        end else begin
          bus_rdata = (op_cnt % 4 == 3) ? dev_cr : MEM_WORD;
        end
        op_cnt++;
      end else begin
        wait_cnt++;
      end
    end else begin
      wait_cnt = 0;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      finish_run();
    end
  end

  // Issue one command and wait for its outcome; counts cycles spent busy.
  task automatic run_cmd(input bit rd, input logic [15:0] v,
                         output bit got_done, output bit got_rej, output int busy_cyc);
    got_done = 0; got_rej = 0; busy_cyc = 0;
    op_cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_read = rd; cmd_value = v;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 200; i++) begin
      if (done) begin got_done = 1; break; end
      if (reject) begin got_rej = 1; break; end
      if (busy) busy_cyc++;
      @(negedge clk);
    end
  endtask

  task automatic check_ops(input bit rd, input logic [15:0] v, input string req);
    chk(op_cnt == 4, req, op_cnt, 4);
    for (int i = 0; i < 4; i++) begin
      bit exp_we = (i == 2) || (i == 3 && !rd);
      chk(log_addr[i] == '1, "R2 address", 32'(log_addr[i]), 32'hFFFFF);
      chk(log_we[i] == exp_we, req, 32'(log_we[i]), 32'(exp_we));
      if (i == 2) chk(log_wd[i] == 16'h0000, "R4 third op data", 32'(log_wd[i]), 0);
      if (i == 3 && !rd) chk(log_wd[i] == v, "R3 fourth op data", 32'(log_wd[i]), 32'(v));
    end
  endtask

  task automatic t_reset();
    chk(cfg_shadow == 16'h0070, "R1 shadow", 32'(cfg_shadow), 32'h70);
    chk(!pin_sleep_blocked && !busy && !done && !reject && !bus_req, "R1 idle outputs",
        {pin_sleep_blocked, busy, done, reject, bus_req}, 0);
  endtask

  task automatic t_read(input int l, input logic [15:0] exp);
    bit d, r; int bc;
    logic flag0 = pin_sleep_blocked;
    logic [15:0] sh0 = cfg_shadow;
    lat = l;
    run_cmd(1'b1, 16'h1234, d, r, bc);
    chk(d && !r, "R4 read completes", {d, r}, 2);
    check_ops(1'b1, 16'h0, "R4 op kinds");
    chk(rd_value == exp, "R4 read value", 32'(rd_value), 32'(exp));
    chk(bc == 4 * (l + 1), "R9 busy length", bc, 4 * (l + 1));
    chk(pin_sleep_blocked == flag0, "R8 read leaves flag", 32'(pin_sleep_blocked), 32'(flag0));
    chk(cfg_shadow == sh0, "R10 read leaves shadow", 32'(cfg_shadow), 32'(sh0));
  endtask

  task automatic t_load(input int l, input logic [15:0] v);
    bit d, r; int bc;
    logic [15:0] rd0 = rd_value;
    lat = l;
    run_cmd(1'b0, v, d, r, bc);
    chk(d && !r, "R3 load completes", {d, r}, 2);
    check_ops(1'b0, v, "R3 op kinds");
    chk(cfg_shadow == v, "R7 shadow value", 32'(cfg_shadow), 32'(v));
    chk(pin_sleep_blocked, "R8 flag set", 32'(pin_sleep_blocked), 1);
    chk(bc == 4 * (l + 1), "R9 busy length", bc, 4 * (l + 1));
    chk(rd_value == rd0, "R10 load leaves rd_value", 32'(rd_value), 32'(rd0));
    @(negedge clk);
    chk(!done, "R10 done one cycle", 32'(done), 0);
  endtask

  task automatic t_refuse(input logic [15:0] v, input string req);
    bit d, r; int bc;
    logic [15:0] sh0 = cfg_shadow;
    logic [15:0] rd0 = rd_value;
    logic flag0 = pin_sleep_blocked;
    run_cmd(1'b0, v, d, r, bc);
    chk(r && !d, req, {d, r}, 1);
    chk(!bus_req && !busy, req, {bus_req, busy}, 0);
    @(negedge clk);
    chk(!reject, req, 32'(reject), 0);
    repeat (3) @(negedge clk);
    chk(op_cnt == 0, req, op_cnt, 0);
    chk(cfg_shadow == sh0 && rd_value == rd0 && pin_sleep_blocked == flag0, req,
        32'(cfg_shadow), 32'(sh0));
  endtask

  task automatic t_busy_ignore();
    logic [15:0] rd0 = rd_value;
    lat = 3;
    op_cnt = 0;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_read = 1'b0; cmd_value = 16'h00D0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy, "R9 busy after accept", 32'(busy), 1);
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_is_read = 1'b1; cmd_value = 16'h0000;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 100 && !done; i++) @(negedge clk);
    chk(done, "R9 first command done", 32'(done), 1);
    repeat (10) @(negedge clk);
    chk(op_cnt == 4, "R9 second command ignored", op_cnt, 4);
    chk(!busy && !bus_req, "R9 idle after", {busy, bus_req}, 0);
    check_ops(1'b0, 16'h00D0, "R3 op kinds under busy");
    chk(cfg_shadow == 16'h00D0, "R9 shadow from first", 32'(cfg_shadow), 32'h00D0);
    chk(rd_value == rd0, "R10 rd_value kept", 32'(rd_value), 32'(rd0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read(0, 16'h0070);
    t_refuse(16'h0060, "R6 deep power-down refused");
    t_refuse(16'h0170, "R5 upper reserved refused");
    t_refuse(16'h0078, "R5 bit3 refused");
    t_refuse(16'h8070, "R5 top bit refused");
    t_load(2, 16'h00F0);
    t_read(1, 16'h00F0);
    t_load(0, 16'h0014);
    t_load(1, 16'h0037);
    t_read(0, 16'h0037);
    t_busy_ignore();
    t_read(2, 16'h00D0);
    finish_run();
  end
endmodule